// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block is an up-counting timer with a single compare channel. It waits for a chosen edge on an external trigger line and then starts counting. It produces either one delayed pulse, or a pulse train that repeats for as long as it runs. The delay before the pulse is set by a compare value. The end of each period is set by an auto-reload value. A clock-enable prescaler slows the count.

Software programs the channel through a small write-only register port:

- a control word,
- a prescaler value,
- a compare value,
- an auto-reload value,
- a command word whose bit 0 forces an update.

The count is visible on `cnt_out`, and the run state is visible on `cnt_en`. This lets surrounding logic and the bench follow the timing. The pin output `pulse_out` is registered. It goes high once the count reaches the compare value, and goes low when the count wraps from the auto-reload value to zero.

Top module: `trig_pulse_timer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `cnt_out` is 0, `cnt_en` is 0 and `pulse_out` is 0. At reset the compare and auto-reload values are all ones, the prescaler value is 0 and the control word is 0.
- R2: A trigger edge sets `cnt_en` three clocks after `trig_in` changes, with the count starting from 0. Control bit 4 (address 0) selects the edge: a rising edge when it is 0, a falling edge when it is 1. An edge of the other direction never starts the counter.
- R3: A trigger edge that arrives while `cnt_en` is 1 has no effect. A one-shot run stops exactly as it would without that edge, and stays stopped afterwards.
- R4: While enabled, the count advances by one every PSC+1 clocks. When it reaches the active auto-reload value it wraps to 0 instead, and that wrap is an update event.
- R5: `pulse_out` follows the count one clock later. It is high when the count is at least the compare value. With prescaler value P, compare C and auto-reload A, the output rises 4+C*(P+1) clocks after the trigger change and stays high for (A-C+1)*(P+1) clocks.
- R6: With control bit 0 (one-shot) set, `cnt_en` is cleared at the wrap. The counter then holds at 0 until the next trigger, and the one-shot run lasts (A+1)*(P+1) clocks from the start.
- R7: With control bit 0 clear, the counter keeps wrapping. Successive pulse rises are (A+1)*(P+1) clocks apart.
- R8: When control bit 1 (compare preload) or bit 2 (auto-reload preload) is set, a write to address 2 (compare) or address 3 (auto-reload) waits for the next update event. A write that lands in the same cycle as a wrap leaves the old pending value active for the following period; the new value takes effect one period later.
- R9: When the matching preload bit is clear, a write to the compare or auto-reload address is active from the next clock.
- R10: Writing address 4 with bit 0 set forces an update event. It sets the count and prescaler phase to 0, loads all pending values, and leaves `cnt_en` unchanged.
- R11: Control bit 3 inverts the pin. When it is set, `pulse_out` is the complement of the reference level, including while the counter is idle.
- R12: A compare value of 0 keeps the output high for the whole period. A compare value above the auto-reload value keeps it low for the whole run.
- R13: A value written to address 1 (prescaler) is used only after the next update event, whether that is a wrap or a forced update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 prescaler, 2 compare, 3 auto-reload, 4 command |
| wr_data | input | DATA_W (16) | Write data |
| trig_in | input | 1 | Asynchronous external trigger |
| pulse_out | output | 1 | Registered pulse output after polarity |
| cnt_out | output | CNT_W (16) | Current count |
| cnt_en | output | 1 | Counter enable, high while running |

## Verification
Two functions can fall in the same cycle:

- a software write to the compare register, with preload on;
- the rollover update that moves the pending compare value into the active one.

The bench provokes this in repeating mode with a prescaler of 0. It watches `cnt_out` until it equals the auto-reload value, then drives the write so that it lands on the very clock edge of the wrap. It judges the result by the next two pulse widths: the first must still reflect the old compare value, and the second must reflect the new one. A forced update that arrives in the middle of a run is also checked: the count must return to 0 while `cnt_en` stays high.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

   localparam int unsigned TPT_ADDR_W = 3;

   typedef enum logic [TPT_ADDR_W-1:0] {
      REG_CTRL = 3'd0,
      REG_PSC  = 3'd1,
      REG_CMP  = 3'd2,
      REG_ARR  = 3'd3,
      REG_CMD  = 3'd4
   } tpt_reg_e;

   // packed: trig_fall is bit 4, one_shot is bit 0
   typedef struct packed {
      logic trig_fall;
      logic out_inv;
      logic arr_pre;
      logic cmp_pre;
      logic one_shot;
   } tpt_ctrl_t;

   localparam int unsigned TPT_CTRL_W = $bits(tpt_ctrl_t);
   localparam int unsigned TPT_CMD_UG = 0;

endpackage

// File: rtl/tpt_trig_detect.sv
module tpt_trig_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic fall_sel,
   output logic trig_evt
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpt_trig_detect: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trig_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign level    = sync_q[STAGES-1];
   assign trig_evt = fall_sel ? (!level && last_q) : (level && !last_q);

endmodule

// File: rtl/tpt_prescaler.sv
module tpt_prescaler #(
   parameter int unsigned PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] limit,
   output logic             tick
);

   logic [PSC_W-1:0] phase_q;

   assign tick = run && (phase_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!run || restart || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/tpt_regs.sv
module tpt_regs
   import tpt_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [TPT_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  cnt_wrap,
   output tpt_ctrl_t             ctrl,
   output logic [CNT_W-1:0]      cmp_act,
   output logic [CNT_W-1:0]      arr_act,
   output logic [PSC_W-1:0]      psc_act,
   output logic                  force_upd
);

   logic [CNT_W-1:0] cmp_pend;
   logic [CNT_W-1:0] arr_pend;
   logic [PSC_W-1:0] psc_pend;
   logic             upd;
   logic             wr_ctrl, wr_psc, wr_cmp, wr_arr;

   assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
   assign wr_psc    = wr_en && (wr_addr == REG_PSC);
   assign wr_cmp    = wr_en && (wr_addr == REG_CMP);
   assign wr_arr    = wr_en && (wr_addr == REG_ARR);
   assign force_upd = wr_en && (wr_addr == REG_CMD) && wr_data[TPT_CMD_UG];
   assign upd       = cnt_wrap || force_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl <= tpt_ctrl_t'(wr_data[TPT_CTRL_W-1:0]);
      end
   end

   // pending registers always capture writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_pend <= '1;
         arr_pend <= '1;
         psc_pend <= '0;
      end else begin
         if (wr_cmp) cmp_pend <= wr_data[CNT_W-1:0];
         if (wr_arr) arr_pend <= wr_data[CNT_W-1:0];
         if (wr_psc) psc_pend <= wr_data[PSC_W-1:0];
      end
   end

   // an update copies the value pending before this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= '1;
         arr_act <= '1;
         psc_act <= '0;
      end else begin
         if (ctrl.cmp_pre) begin
            if (upd) cmp_act <= cmp_pend;
         end else if (wr_cmp) begin
            cmp_act <= wr_data[CNT_W-1:0];
         end
         if (ctrl.arr_pre) begin
            if (upd) arr_act <= arr_pend;
         end else if (wr_arr) begin
            arr_act <= wr_data[CNT_W-1:0];
         end
         if (upd) psc_act <= psc_pend;
      end
   end

endmodule

// File: rtl/tpt_out_stage.sv
module tpt_out_stage #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic             inv,
   output logic             pulse
);

   logic ref_lvl;

   assign ref_lvl = (cnt >= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
      end else begin
         pulse <= ref_lvl ^ inv;
      end
   end

endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
   import tpt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PSC_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [TPT_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  trig_in,
   output logic                  pulse_out,
   output logic [CNT_W-1:0]      cnt_out,
   output logic                  cnt_en
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("trig_pulse_timer: CNT_W must be at least 2");
      end
      if (DATA_W < CNT_W || DATA_W < PSC_W || DATA_W < TPT_CTRL_W) begin : g_bad_data
         $error("trig_pulse_timer: DATA_W too narrow for the registers");
      end
   endgenerate

   tpt_ctrl_t        ctrl;
   logic [CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0] arr_act;
   logic [PSC_W-1:0] psc_act;
   logic             force_upd;
   logic             trig_evt;
   logic             tick;
   logic             cnt_wrap;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;

   tpt_trig_detect #(.STAGES(SYNC_STAGES)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .fall_sel (ctrl.trig_fall),
      .trig_evt (trig_evt)
   );

   tpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cnt_wrap  (cnt_wrap),
      .ctrl      (ctrl),
      .cmp_act   (cmp_act),
      .arr_act   (arr_act),
      .psc_act   (psc_act),
      .force_upd (force_upd)
   );

   tpt_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (force_upd),
      .limit   (psc_act),
      .tick    (tick)
   );

   assign cnt_wrap = tick && (cnt_q >= arr_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (force_upd) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_wrap ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (!en_q) begin
         if (trig_evt) en_q <= 1'b1;
      end else if (cnt_wrap && ctrl.one_shot) begin
         en_q <= 1'b0;
      end
   end

   tpt_out_stage #(.CNT_W(CNT_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt_q),
      .cmp   (cmp_act),
      .inv   (ctrl.out_inv),
      .pulse (pulse_out)
   );

   assign cnt_out = cnt_q;
   assign cnt_en  = en_q;

endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_out,
   input logic             cnt_en,
   input logic             pulse_out,
   input logic [CNT_W-1:0] cmp_act,
   input logic             out_inv
);

   p_idle_in_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (cnt_out == '0 && !cnt_en && !pulse_out));

   p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_en) |-> (cnt_out == '0));

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_out != $past(cnt_out)) |-> (cnt_out == $past(cnt_out) + 1'b1 || cnt_out == '0));

   p_out_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_out == $past((cnt_out >= cmp_act) ^ out_inv));

   p_stop_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnt_en) |-> (cnt_out == '0));

endmodule

bind trig_pulse_timer tpt_checker #(.CNT_W(CNT_W)) u_tpt_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_out   (cnt_out),
   .cnt_en    (cnt_en),
   .pulse_out (pulse_out),
   .cmp_act   (cmp_act),
   .out_inv   (ctrl.out_inv)
);

// File: tb/test_trig_pulse_timer.sv
module test_trig_pulse_timer;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        trig_in = 1'b0;
   logic        pulse_out;
   logic [15:0] cnt_out;
   logic        cnt_en;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   trig_pulse_timer i_trig_pulse_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .trig_in   (trig_in),
      .pulse_out (pulse_out),
      .cnt_out   (cnt_out),
      .cnt_en    (cnt_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_trig(input logic v);
      @(negedge clk);
      trig_in = v;
   endtask

   task automatic capture(input bit inv, input int max_n,
                          output int rise_n, output int fall_n, output int stop_n);
      bit seen;
      bit lvl;
      rise_n = -1; fall_n = -1; stop_n = -1; seen = 1'b0;
      for (int n = 1; n <= max_n; n++) begin
         @(negedge clk);
         lvl = pulse_out ^ inv;
         if (rise_n < 0 && lvl) rise_n = n;
         else if (rise_n >= 0 && fall_n < 0 && !lvl) fall_n = n;
         if (cnt_en) seen = 1'b1;
         else if (seen && stop_n < 0) stop_n = n;
      end
   endtask

   task automatic run_check(input string req, input bit inv, input int max_n,
                            input int er, input int ef, input int es);
      int r, f, s;
      capture(inv, max_n, r, f, s);
      chk(req, "rise clock", r, er);
      chk(req, "fall clock", f, ef);
      chk(req, "stop clock", s, es);
      chk(req, "count after stop", int'(cnt_out), 0);
   endtask

   task automatic meas_high(output int w);
      w = 0;
      for (int k = 0; k < 200 && pulse_out; k++) @(negedge clk);
      for (int k = 0; k < 200 && !pulse_out; k++) @(negedge clk);
      for (int k = 0; k < 200 && pulse_out; k++) begin
         w++;
         @(negedge clk);
      end
   endtask

   task automatic wait_stop();
      for (int k = 0; k < 400 && cnt_en; k++) @(negedge clk);
   endtask

   // R1: reset values
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", "cnt_en in reset", int'(cnt_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "count", int'(cnt_out), 0);
      chk("R1", "cnt_en", int'(cnt_en), 0);
      chk("R1", "pulse", int'(pulse_out), 0);
   endtask

   // R2 R5 R6 R9: basic one-shot, P=0 C=3 A=7
   task automatic t_one_shot();
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'd3);
      wr(3'd3, 16'd7);
      set_trig(1'b1);
      run_check("R5_R6_R9", 1'b0, 40, 7, 12, 11);
      set_trig(1'b0);
   endtask

   // R3: edge during run ignored
   task automatic t_retrigger();
      set_trig(1'b1);
      repeat (4) @(negedge clk);
      trig_in = 1'b0;
      repeat (2) @(negedge clk);
      trig_in = 1'b1;
      wait_stop();
      repeat (12) @(negedge clk);
      chk("R3", "cnt_en after retrigger", int'(cnt_en), 0);
      chk("R3", "count after retrigger", int'(cnt_out), 0);
      set_trig(1'b0);
   endtask

   // R13 R4: prescaler loaded only at update
   task automatic t_prescale();
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd1);
      wr(3'd3, 16'd3);
      set_trig(1'b1);
      run_check("R13 old prescaler", 1'b0, 40, 5, 8, 7);
      set_trig(1'b0);
      wr(3'd2, 16'd2);
      wr(3'd3, 16'd4);
      set_trig(1'b1);
      run_check("R4_R13 new prescaler", 1'b0, 60, 10, 19, 18);
      set_trig(1'b0);
      wr(3'd1, 16'd0);
      wr(3'd4, 16'h0001);
   endtask

   // R7 R8: repeating mode and write colliding with wrap
   task automatic t_repeat_collide();
      int first, second, w1, w2;
      bit prev;
      wr(3'd2, 16'd2);
      wr(3'd3, 16'd5);
      wr(3'd0, 16'h0002);
      set_trig(1'b1);
      first = -1; second = -1; prev = pulse_out;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         if (pulse_out && !prev) begin
            if (first < 0) first = n;
            else if (second < 0) second = n;
         end
         prev = pulse_out;
      end
      chk("R7", "repeat period", second - first, 6);
      for (int k = 0; k < 20 && cnt_out != 16'd5; k++) @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd4;
      @(negedge clk);
      wr_en = 1'b0;
      meas_high(w1);
      meas_high(w2);
      chk("R8", "width in period after colliding write", w1, 4);
      chk("R8", "width one period later", w2, 2);
      wr(3'd0, 16'h0003);
      wait_stop();
      chk("R6", "stopped after repeat", int'(cnt_en), 0);
      set_trig(1'b0);
   endtask

   // R9 R10: preload on auto-reload, forced update
   task automatic t_force_update();
      wr(3'd0, 16'h0005);
      wr(3'd3, 16'd9);
      wr(3'd2, 16'd2);
      set_trig(1'b1);
      run_check("R8_R9 pending auto-reload", 1'b0, 40, 6, 10, 9);
      set_trig(1'b0);
      wr(3'd3, 16'd4);
      wr(3'd4, 16'h0001);
      set_trig(1'b1);
      run_check("R10 load by forced update", 1'b0, 40, 6, 9, 8);
      set_trig(1'b0);
      set_trig(1'b1);
      for (int k = 0; k < 20 && cnt_out != 16'd2; k++) @(negedge clk);
      wr(3'd4, 16'h0001);
      chk("R10", "count after mid-run update", int'(cnt_out), 0);
      chk("R10", "cnt_en after mid-run update", int'(cnt_en), 1);
      wait_stop();
      set_trig(1'b0);
   endtask

   // R2: falling edge selection
   task automatic t_fall_edge();
      wr(3'd0, 16'h0011);
      set_trig(1'b1);
      repeat (8) @(negedge clk);
      chk("R2", "rising edge ignored in falling mode", int'(cnt_en), 0);
      set_trig(1'b0);
      run_check("R2 falling start", 1'b0, 40, 6, 9, 8);
   endtask

   // R11: inverted output
   task automatic t_invert();
      wr(3'd0, 16'h0009);
      repeat (2) @(negedge clk);
      chk("R11", "idle level inverted", int'(pulse_out), 1);
      set_trig(1'b1);
      run_check("R11 inverted pulse", 1'b1, 40, 6, 9, 8);
      set_trig(1'b0);
   endtask

   // R12: compare extremes
   task automatic t_cmp_edges();
      int lows, highs;
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'd0);
      repeat (2) @(negedge clk);
      chk("R12", "compare 0 idle", int'(pulse_out), 1);
      set_trig(1'b1);
      lows = 0;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (!pulse_out) lows++;
      end
      chk("R12", "low clocks with compare 0", lows, 0);
      set_trig(1'b0);
      wr(3'd2, 16'd7);
      set_trig(1'b1);
      highs = 0;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         if (pulse_out) highs++;
      end
      chk("R12", "high clocks with compare above reload", highs, 0);
      chk("R12", "stopped", int'(cnt_en), 0);
      set_trig(1'b0);
   endtask

   initial begin
      t_reset();
      t_one_shot();
      t_retrigger();
      t_prescale();
      t_repeat_collide();
      t_force_update();
      t_fall_edge();
      t_invert();
      t_cmp_edges();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule